// File: doc/BRIEF.md
# Peripheral ID Tree Walker

This block turns a 12-bit peripheral identifier into an 8-bit channel index by walking a binary decision tree held in a local table of 255 words, each 32 bits wide. The identifier is the 4-bit slave number placed above the 8-bit peripheral number. Every table word names one identifier bit to test. For each value of that bit, the word either points at another word or ends the walk with a result.

The table is filled through a single-cycle write port. A lookup is offered with a valid/ready handshake. The walker reads one table word per clock, starting at word 0. It returns a hit flag and a channel index on a response port that holds until the consumer accepts it. A walk that has not ended after a fixed number of visited words stops and reports a miss. A walk that would branch to an index outside the table also reports a miss.

Top module: `pid_tree_walker`

## Requirements
- R1: After reset `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: The identifier is `{req_sid_i, req_per_i}`, with the slave number in bits 11:8. Bits 21:18 of a table word select the identifier bit to test. A selector value of 12 to 15 always tests as 0.
- R3: When the tested bit is 1, word bit 8 is the continue flag and word bits 7:0 give the next word index (flag 1) or the result channel (flag 0).
- R4: When the tested bit is 0, word bit 17 is the continue flag and word bits 16:9 give the next word index (flag 1) or the result channel (flag 0).
- R5: Every walk starts at word 0 and visits one word per clock. A walk that visits N words raises `rsp_valid_o` N clock edges after the edge that accepted the request.
- R6: If the 16th visited word asks to continue, the walk ends as a miss (`rsp_found_o` = 0) on that same edge. A terminal result in the 16th word is still a hit.
- R7: A continue to index 255 ends the walk as a miss on the edge that reads that word.
- R8: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response stays valid and `rsp_found_o` and `rsp_chan_o` do not change.
- R9: `req_ready_o` is 0 from the accepting edge until the edge on which the response is handed off. A request offered in that time is neither accepted nor does it change the result.
- R10: A table write takes effect for every lookup accepted after it. Rewriting a word changes the results of later lookups that pass through it.
- R11: A miss always reports `rsp_chan_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 8 | Table word index to write |
| tbl_wdata_i | input | 32 | Table word data |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker idle, request can be accepted |
| req_sid_i | input | 4 | Slave number (identifier bits 11:8) |
| req_per_i | input | 8 | Peripheral number (identifier bits 7:0) |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_ready_i | input | 1 | Consumer accepts the result |
| rsp_found_o | output | 1 | 1 on hit, 0 on miss |
| rsp_chan_o | output | 8 | Channel index on hit, 0 on miss |

## Verification
The assertions assume that the words the walker visits were written before the lookup started. An unwritten word would steer the walk on unknown data. The handshake checks also assume that the consumer may hold `rsp_ready_i` low for any number of cycles. The bench writes every word that a test's tree reaches before it issues that test's lookups. It changes table words only while the walker is idle. It drives all inputs one time unit after a rising edge, so no input changes at a sampling edge.

// File: rtl/pid_tree_pkg.sv
package pid_tree_pkg;
  localparam int unsigned SID_W   = 4;
  localparam int unsigned PER_W   = 8;
  localparam int unsigned PID_W   = SID_W + PER_W;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PAD_W   = WORD_W - SEL_W - 2 * (IDX_W + 1);
  localparam int unsigned TEST_W  = 1 << SEL_W;

  // word layout is fixed by the table contents software builds
  typedef struct packed {
    logic [PAD_W-1:0] pad;
    logic [SEL_W-1:0] sel;   // 21:18
    logic             go0;   // 17
    logic [IDX_W-1:0] val0;  // 16:9
    logic             go1;   // 8
    logic [IDX_W-1:0] val1;  // 7:0
  } tree_word_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WALK,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/pid_tree_table.sv
module pid_tree_table
  import pid_tree_pkg::*;
#(
  parameter int unsigned ENTRY_CNT = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output tree_word_t        rdata_o
);
  logic [WORD_W-1:0] mem_q [ENTRY_CNT];

  always_ff @(posedge clk_i) begin
    if (we_i && (32'(waddr_i) < ENTRY_CNT)) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = (32'(raddr_i) < ENTRY_CNT) ? tree_word_t'(mem_q[raddr_i]) : '0;

  // walker never presents an index outside the table
  tbl_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(raddr_i) < ENTRY_CNT);
endmodule

// File: rtl/pid_tree_step.sv
module pid_tree_step
  import pid_tree_pkg::*;
(
  input  tree_word_t       word_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             go_o,
  output logic [IDX_W-1:0] val_o
);
  logic [TEST_W-1:0] pid_ext;
  logic              bit_v;

  assign pid_ext = TEST_W'(pid_i);   // selectors past the ID test as 0
  assign bit_v   = pid_ext[word_i.sel];

  always_comb begin
    if (bit_v) begin
      go_o  = word_i.go1;
      val_o = word_i.val1;
    end else begin
      go_o  = word_i.go0;
      val_o = word_i.val0;
    end
  end
endmodule

// File: rtl/pid_tree_walker.sv
module pid_tree_walker
  import pid_tree_pkg::*;
#(
  parameter int unsigned ENTRY_CNT = 255,
  parameter int unsigned MAX_STEPS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tbl_we_i,
  input  logic [7:0]       tbl_addr_i,
  input  logic [31:0]      tbl_wdata_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [3:0]       req_sid_i,
  input  logic [7:0]       req_per_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_found_o,
  output logic [7:0]       rsp_chan_o
);
  localparam int unsigned STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);

  walk_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [STEP_W-1:0] step_q;
  logic [PID_W-1:0]  pid_q;
  logic              found_q;
  logic [IDX_W-1:0]  chan_q;

  tree_word_t        cur_word;
  logic              go;
  logic [IDX_W-1:0]  val;
  logic              bad_idx;

  pid_tree_table #(.ENTRY_CNT(ENTRY_CNT)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_wdata_i),
    .raddr_i (idx_q),
    .rdata_o (cur_word)
  );

  pid_tree_step u_step (
    .word_i (cur_word),
    .pid_i  (pid_q),
    .go_o   (go),
    .val_o  (val)
  );

  assign bad_idx = 32'(val) >= ENTRY_CNT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      step_q  <= '0;
      pid_q   <= '0;
      found_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          pid_q   <= {req_sid_i, req_per_i};
          idx_q   <= '0;
          step_q  <= '0;
          state_q <= ST_WALK;
        end
        ST_WALK: begin
          if (!go) begin
            found_q <= 1'b1;
            chan_q  <= val;
            state_q <= ST_DONE;
          end else if (bad_idx || step_q == LAST_STEP) begin
            found_q <= 1'b0;
            chan_q  <= '0;
            state_q <= ST_DONE;
          end else begin
            idx_q  <= val;
            step_q <= step_q + 1'b1;
          end
        end
        ST_DONE: if (rsp_ready_i) begin
          idx_q   <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = state_q == ST_IDLE;
  assign rsp_valid_o = state_q == ST_DONE;
  assign rsp_found_o = found_q;
  assign rsp_chan_o  = chan_q;

  // R5
  walk_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (idx_q == '0 && step_q == '0));
  // R6
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK) |-> (32'(step_q) < MAX_STEPS));
  // R8
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_found_o) && $stable(rsp_chan_o)));
  // R9
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && rsp_valid_o));
  // R11
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_found_o) |-> (rsp_chan_o == '0));
endmodule

// File: tb/pid_tree_walker_test.sv
module pid_tree_walker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [7:0] tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_sid = '0;
  logic [7:0] req_per = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic       rsp_found;
  logic [7:0] rsp_chan;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pid_tree_walker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_sid_i(req_sid), .req_per_i(req_per),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_found_o(rsp_found), .rsp_chan_o(rsp_chan)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] sel, input logic c0,
      input logic [7:0] r0, input logic c1, input logic [7:0] r1);
    return {10'b0, sel, c0, r0, c1, r1};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    tbl_we = 1'b1; tbl_addr = a; tbl_wdata = d;
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic lookup(input logic [3:0] sid, input logic [7:0] per,
      input bit exp_f, input logic [7:0] exp_c, input int exp_lat, input string tag);
    int lat = 0;
    bit busy_ok = 1'b1;
    logic [7:0] c0;
    req_sid = sid; req_per = per; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (!rsp_valid && lat < 40) begin
      if (req_ready) busy_ok = 1'b0;
      @(posedge clk); #1;
      lat++;
    end
    check(lat == exp_lat, {tag, " R5 latency"}, lat, exp_lat);
    check(rsp_found == exp_f, {tag, " found"}, int'(rsp_found), int'(exp_f));
    check(rsp_chan == exp_c, {tag, " chan"}, rsp_chan, exp_c);
    check(busy_ok, "R9 ready low while walking", 1, 0);
    c0 = rsp_chan;
    @(posedge clk); #1;
    check(rsp_valid && rsp_chan == c0 && rsp_found == exp_f, "R8 response held",
          rsp_chan, c0);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    check(!rsp_valid && req_ready, "R9 handoff returns to idle", int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_single();
    wr(8'd0, mk(4'd0, 1'b0, 8'h20, 1'b0, 8'h21));
    lookup(4'h0, 8'h01, 1'b1, 8'h21, 1, "R3 bit1 terminal");
    lookup(4'h0, 8'h00, 1'b1, 8'h20, 1, "R4 bit0 terminal");
  endtask

  task automatic t_tree();
    wr(8'd0, mk(4'd11, 1'b1, 8'd3, 1'b1, 8'd5));
    wr(8'd3, mk(4'd8,  1'b0, 8'h30, 1'b0, 8'h31));
    wr(8'd5, mk(4'd4,  1'b0, 8'h50, 1'b0, 8'h51));
    lookup(4'h8, 8'h10, 1'b1, 8'h51, 2, "R2 R3 slave bit3 path");
    lookup(4'h1, 8'h00, 1'b1, 8'h31, 2, "R2 R4 slave bit0 path");
    lookup(4'h8, 8'h00, 1'b1, 8'h50, 2, "R2 per bit4 zero");
  endtask

  task automatic t_high_sel();
    wr(8'd0, mk(4'd13, 1'b0, 8'h0A, 1'b0, 8'h0B));
    lookup(4'hF, 8'hFF, 1'b1, 8'h0A, 1, "R2 selector above id");
  endtask

  task automatic t_bound();
    for (int i = 0; i < 16; i++) wr(8'(i), mk(4'd0, 1'b1, 8'(i + 1), 1'b1, 8'(i + 1)));
    wr(8'd16, mk(4'd0, 1'b0, 8'h77, 1'b0, 8'h77));
    lookup(4'h2, 8'h03, 1'b0, 8'h00, 16, "R6 R11 bound miss");
    wr(8'd15, mk(4'd0, 1'b0, 8'h66, 1'b0, 8'h66));
    lookup(4'h2, 8'h03, 1'b1, 8'h66, 16, "R6 R10 terminal at last step");
  endtask

  task automatic t_busy();
    int lat = 0;
    req_sid = 4'h1; req_per = 8'h01; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    repeat (3) begin @(posedge clk); #1; lat++; end
    req_sid = 4'h9; req_per = 8'hAA; req_valid = 1'b1;
    repeat (2) begin @(posedge clk); #1; lat++; end
    req_valid = 1'b0;
    while (!rsp_valid && lat < 40) begin @(posedge clk); #1; lat++; end
    check(lat == 16 && rsp_found && rsp_chan == 8'h66, "R9 busy request ignored",
          rsp_chan, 8'h66);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!rsp_valid && req_ready, "R9 no second walk started", int'(rsp_valid), 0);
  endtask

  task automatic t_bad_idx();
    wr(8'd0, mk(4'd0, 1'b1, 8'hFF, 1'b0, 8'h12));
    lookup(4'h0, 8'h00, 1'b0, 8'h00, 1, "R7 R11 branch to 255");
    lookup(4'h0, 8'h01, 1'b1, 8'h12, 1, "R7 R10 other side hit");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_single();
    t_tree();
    t_high_sel();
    t_bound();
    t_busy();
    t_bad_idx();
    finish_run();
  end
endmodule